// File: doc/BRIEF.md
# Circular Interrupt Queue Writer

This block turns per-channel event reports from a protocol engine into entries of a circular interrupt queue. The queue lives in a small on-chip memory that the host shares. Each report arrives through a valid/ready handshake. The block then stores it at its own write pointer as an entry with four parts: a valid flag, a wrap flag, the channel number and the event bits.

The queue length is not a parameter. At initialization the host zeroes every entry and sets the wrap flag only in the slot that ends the ring. After the block writes a slot whose wrap flag is set, it returns to address 0. When the write pointer lands on an entry that is still valid, the queue is full. In that case the report is dropped and an overflow event is raised.

Each added entry raises a global-interrupt event. The two events are cleared by writing 1 to them, and a mask turns them into one level interrupt. The host reads and rewrites entries through a single-cycle host port. This port shares the one memory port with the block and wins when both need it in the same cycle.

Top module: `irq_ring_writer`

## Requirements
- R1: Entry layout, with ENT_W = 2+CHAN_W+EVT_W: bit ENT_W-1 holds valid, bit ENT_W-2 holds wrap, the next CHAN_W bits hold the channel and the low EVT_W bits hold the events. A stored report has valid=1 and the captured channel and events. The wrap bit already in that slot is kept.
- R2: After each stored entry the write pointer moves to the next address. If the slot just written had wrap=1, the pointer moves to address 0 instead. Past the last memory address the pointer wraps to 0 on its own.
- R3: If the slot at the write pointer has valid=1, the report is dropped and the slot keeps its content. The pointer stays where it is, and status bit 1 (overflow) is set.
- R4: Every stored entry sets status bit 0 (global interrupt).
- R5: Writing 1 to a status bit (csr_sel=0) clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: irq is high exactly when some status bit is 1 and its mask bit is 1. The mask is written with csr_sel=1, resets to 0 and is read back on csr_rdata.
- R7: ev_ready is high while idle. After a report is accepted it is low for at least the next cycle, and each handshake produces exactly one entry or one drop.
- R8: A host entry write takes the memory port first. A pending report waits for that cycle, with ev_ready still low, and then checks the slot content as the host left it.
- R9: After reset the write pointer is 0, every entry is 0, status and mask are 0, irq is low and ev_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event report offered |
| ev_ready | output | 1 | Block can accept a report |
| ev_chan | input | CHAN_W | Channel number of the report |
| ev_bits | input | EVT_W | Event bits of the report |
| hq_addr | input | ADDR_W | Host entry address |
| hq_we | input | 1 | Host entry write strobe |
| hq_wdata | input | ENT_W | Entry written by the host |
| hq_rdata | output | ENT_W | Entry at hq_addr, combinational |
| csr_we | input | 1 | Control write strobe |
| csr_sel | input | 1 | 0 selects status, 1 selects mask |
| csr_wdata | input | 2 | Control write data |
| csr_rdata | output | 2 | Selected status or mask value |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can meet in the same cycle. In the first, the engine sets the global-interrupt bit while the host writes 1 to clear it. The bench provokes this by timing the clear to the cycle in which the pending entry is committed, and it expects the bit to read 1 afterwards. In the second, a host entry write and the engine's commit want the memory port together. The bench clears a full slot during the busy cycle, and it expects ev_ready to stay low one cycle longer and the report to land in that slot rather than being dropped.

// File: rtl/irq_ring_writer.sv
module irq_ring_writer #(
  parameter int ADDR_W = 4,
  parameter int CHAN_W = 6,
  parameter int EVT_W  = 8,
  localparam int ENT_W = 2 + CHAN_W + EVT_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [CHAN_W-1:0] ev_chan,
  input  logic [EVT_W-1:0]  ev_bits,
  input  logic [ADDR_W-1:0] hq_addr,
  input  logic              hq_we,
  input  logic [ENT_W-1:0]  hq_wdata,
  output logic [ENT_W-1:0]  hq_rdata,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [1:0]        csr_wdata,
  output logic [1:0]        csr_rdata,
  output logic              irq
);

  logic [ENT_W-1:0]  ring [DEPTH];
  logic [ADDR_W-1:0] wptr;
  logic              busy;
  logic [CHAN_W-1:0] chan_q;
  logic [EVT_W-1:0]  bits_q;
  logic [1:0]        stat, mask;

  logic [ENT_W-1:0] slot;
  logic slot_valid, slot_wrap, go, do_write, do_drop;
  logic [1:0] clr;

  assign slot       = ring[wptr];
  assign slot_valid = slot[ENT_W-1];
  assign slot_wrap  = slot[ENT_W-2];
  assign go         = busy && !hq_we;
  assign do_write   = go && !slot_valid;
  assign do_drop    = go && slot_valid;
  assign ev_ready   = !busy;
  assign hq_rdata   = ring[hq_addr];
  assign clr        = (csr_we && !csr_sel) ? csr_wdata : 2'b00;
  assign csr_rdata  = csr_sel ? mask : stat;
  assign irq        = |(stat & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else if (hq_we) begin
      ring[hq_addr] <= hq_wdata;
    end else if (do_write) begin
      ring[wptr] <= {1'b1, slot_wrap, chan_q, bits_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      busy   <= 1'b0;
      chan_q <= '0;
      bits_q <= '0;
    end else begin
      if (do_write) wptr <= slot_wrap ? '0 : wptr + 1'b1;
      if (ev_valid && ev_ready) begin
        busy   <= 1'b1;
        chan_q <= ev_chan;
        bits_q <= ev_bits;
      end else if (go) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= 2'b00;
      mask <= 2'b00;
    end else begin
      stat <= (stat & ~clr) | {do_drop, do_write};
      if (csr_we && csr_sel) mask <= csr_wdata;
    end
  end

endmodule

// File: rtl/irq_ring_chk.sv
module irq_ring_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              busy,
  input logic              hq_we,
  input logic              do_write,
  input logic              do_drop,
  input logic              slot_wrap,
  input logic [ADDR_W-1:0] wptr,
  input logic [1:0]        stat,
  input logic [1:0]        mask,
  input logic              irq,
  input logic              csr_we,
  input logic              csr_sel,
  input logic [1:0]        csr_wdata
);

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> !ev_ready);

  assert_gint_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> stat[0]);

  assert_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_drop |=> stat[1] && $stable(wptr));

  assert_wrap_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_write && slot_wrap |=> wptr == '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_write && !slot_wrap |=> wptr == ADDR_W'($past(wptr) + 1'b1));

  assert_hold_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !do_write |=> $stable(wptr));

  assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 2'b00 |-> !irq);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && !csr_sel && csr_wdata[0] && !do_write |=> !stat[0]);

  assert_host_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hq_we |=> !ev_ready);

endmodule

bind irq_ring_writer irq_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .busy(busy), .hq_we(hq_we), .do_write(do_write), .do_drop(do_drop),
  .slot_wrap(slot_wrap), .wptr(wptr), .stat(stat), .mask(mask), .irq(irq),
  .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata)
);

// File: tb/sim_irq_ring_writer.sv
`timescale 1ns/1ps
module sim_irq_ring_writer;
  localparam int AW = 4, CW = 6, EW = 8, ENT = 2 + CW + EW, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_ready;
  logic [CW-1:0] ev_chan = '0;
  logic [EW-1:0] ev_bits = '0;
  logic [AW-1:0] hq_addr = '0;
  logic hq_we = 0;
  logic [ENT-1:0] hq_wdata = '0, hq_rdata;
  logic csr_we = 0, csr_sel = 0;
  logic [1:0] csr_wdata = '0, csr_rdata;
  logic irq;

  irq_ring_writer #(.ADDR_W(AW), .CHAN_W(CW), .EVT_W(EW)) u0 (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [AW-1:0] addr; logic [ENT-1:0] data; string tag; } item_t;
  item_t sbq[$];
  logic [ENT-1:0] mdl [DEPTH];
  int mptr = 0;
  int compared = 0, mismatched = 0;
  bit done = 0;

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [ENT-1:0] d);
    @(negedge clk); hq_we = 1; hq_addr = AW'(a); hq_wdata = d;
    @(negedge clk); hq_we = 0;
    mdl[a] = d;
  endtask

  task automatic csr_wr(input logic sel, input logic [1:0] d);
    @(negedge clk); csr_we = 1; csr_sel = sel; csr_wdata = d;
    @(negedge clk); csr_we = 0; csr_sel = 0;
  endtask

  task automatic csr_rd(input logic sel, output logic [1:0] v);
    csr_sel = sel; #1; v = csr_rdata; csr_sel = 0;
  endtask

  // mode 0 plain, 1 status clear during commit cycle, 2 host clears target slot in busy cycle
  task automatic send(input logic [CW-1:0] ch, input logic [EW-1:0] b, input int mode, input string tag);
    item_t it;
    @(negedge clk); ev_valid = 1; ev_chan = ch; ev_bits = b;
    if (mode == 2) mdl[mptr] = '0;
    it.addr = AW'(mptr); it.tag = tag;
    if (mdl[mptr][ENT-1]) begin
      it.data = mdl[mptr];
    end else begin
      mdl[mptr] = {1'b1, mdl[mptr][ENT-2], ch, b};
      it.data = mdl[mptr];
      mptr = mdl[mptr][ENT-2] ? 0 : (mptr + 1) % DEPTH;
    end
    sbq.push_back(it);
    @(negedge clk); ev_valid = 0;
    chk("R7 ready low after accept", ev_ready, 0);
    if (mode == 1) begin csr_we = 1; csr_sel = 0; csr_wdata = 2'b01; end
    if (mode == 2) begin hq_we = 1; hq_addr = it.addr; hq_wdata = '0; end
    @(negedge clk);
    csr_we = 0; hq_we = 0;
    if (mode == 2) begin
      chk("R8 ready held during host write", ev_ready, 0);
      @(negedge clk);
    end
    chk("R7 ready back", ev_ready, 1);
  endtask

  task automatic drain();
    while (sbq.size() > 0) begin
      item_t it = sbq.pop_front();
      hq_addr = it.addr; #1;
      chk(it.tag, hq_rdata, it.data);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [1:0] v;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 ready", ev_ready, 1);
    chk("R9 irq", irq, 0);
    csr_rd(0, v); chk("R9 status", v, 0);
    csr_rd(1, v); chk("R9 mask", v, 0);
    hq_addr = 0; #1; chk("R9 entry zero", hq_rdata, 0);

    host_wr(5, {2'b01, {(ENT-2){1'b0}}});
    send(6'h11, 8'hA1, 0, "R1 entry 0");
    chk("R6 irq masked", irq, 0);
    csr_wr(1, 2'b11);
    csr_rd(1, v); chk("R6 mask readback", v, 3);
    chk("R6 irq on", irq, 1);
    send(6'h22, 8'hB2, 0, "R1 entry 1");
    send(6'h3F, 8'hFF, 0, "R1 entry 2");
    drain();
    csr_rd(0, v); chk("R4 gint set", v, 1);
    csr_wr(0, 2'b00);
    csr_rd(0, v); chk("R5 write 0 keeps", v, 1);
    csr_wr(0, 2'b01);
    csr_rd(0, v); chk("R5 write 1 clears", v, 0);
    chk("R6 irq off", irq, 0);

    send(6'h01, 8'h03, 0, "R2 entry 3");
    send(6'h02, 8'h05, 0, "R2 entry 4");
    send(6'h03, 8'h07, 0, "R1 entry 5 wrap kept");
    drain();
    hq_addr = 5; #1; chk("R1 wrap bit kept", hq_rdata[ENT-2], 1);

    send(6'h04, 8'h09, 0, "R3 slot 0 untouched");
    drain();
    csr_rd(0, v); chk("R3 overflow status", v, 3);
    host_wr(0, '0);
    send(6'h05, 8'h0B, 0, "R2 wrap to base after wrap flag");
    send(6'h06, 8'h0D, 0, "R3 slot 1 untouched");
    drain();
    csr_wr(0, 2'b11);
    csr_rd(0, v); chk("R5 both cleared", v, 0);

    host_wr(1, '0);
    send(6'h07, 8'h0F, 1, "R5 entry during clear");
    drain();
    csr_rd(0, v); chk("R5 set wins over clear", v, 1);
    csr_wr(0, 2'b01);
    csr_rd(0, v); chk("R5 clear alone", v, 0);

    send(6'h08, 8'h11, 2, "R8 entry after host clear");
    drain();
    csr_rd(0, v); chk("R8 no overflow", v, 1);

    csr_wr(1, 2'b00);
    chk("R6 irq gated by mask", irq, 0);

    for (int i = 0; i < DEPTH; i++) host_wr(i, '0);
    for (int i = 0; i < 14; i++) send(CW'(i), EW'(8'h40 + i), 0, "R2 linear ring");
    drain();
    hq_addr = AW'(DEPTH - 1); #1; chk("R2 last address used", hq_rdata[ENT-1], 1);
    hq_addr = 0; #1; chk("R2 natural wrap", hq_rdata, {2'b10, 6'd13, 8'h4D});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule